// File: doc/BRIEF.md
# Parallel EEPROM Page Load Controller

This block is the write front end of a byte-wide parallel EEPROM whose array is organised in pages of 128 bytes. It watches the host strobes (active-low chip enable, write enable and output enable) together with a 17-bit address and an 8-bit data bus. It gathers every byte written to one page into a page buffer. Each slot of that buffer has its own valid flag. Bytes may arrive in any order, and a byte written twice keeps its latest value.

The load window closes by itself once no byte has been accepted for a set number of clock cycles. The block then raises `busy` and runs a timed programming period. At the end of that period it walks the page slots in ascending order and emits one array write for each slot that was loaded; slots that were not loaded are left alone. All three time constants are counted in clock cycles: the inter-byte gap, the programming time and the power-up hold-off.

The controller is a five-state machine. POR_WAIT holds off writes until supply-good has been high for the power-up delay. IDLE waits for the first byte, and its transition *first byte* enters LOAD. In LOAD, a *same-page byte* stays in LOAD and restarts the gap timer, and the transition *gap expiry* moves to PROG. PROG leaves on *program time elapsed* for COMMIT. COMMIT leaves on *last slot* for IDLE and clears the buffer. Any state takes *supply loss* to POR_WAIT and discards the buffer.

Top module: `eepl_page_loader`

## Requirements
- R1: A host write is in progress only while `ce_n`=0, `we_n`=0 and `oe_n`=1, sampled on the clock. The address is taken in the first cycle of that condition, which is the later of the two falling strobes. The data is taken from the last cycle of that condition, which is the earlier of the two rising strobes.
- R2: A strobe is ignored whenever `oe_n` is low, `ce_n` is high or `we_n` is high. It stores no byte and never raises `busy`.
- R3: Writes are ignored until `pwr_good` has been high for POR_CYCLES clock cycles after reset. When `pwr_good` goes low, `busy` drops on the next clock, the buffer is discarded and the delay starts over.
- R4: Address bits [16:7] form the page number. The first byte of a window fixes the page, and a later byte whose page differs is ignored and does not restart the gap timer.
- R5: Address bits [6:0] select the slot. Slots may be written in any order, and writing a slot again within the window replaces its data.
- R6: The window closes GAP_CYCLES clock cycles after the last accepted byte is taken, and `busy` rises at that edge.
- R7: `busy` stays high for PROG_CYCLES + 128 cycles. During the last 128 of those cycles the slots are visited one per cycle in ascending order, with `cell_addr` = {page, slot}.
- R8: `cell_we` pulses only for slots loaded in the window, with `cell_data` equal to the data loaded there. A window commits anywhere from 1 to 128 bytes.
- R9: Strobes that occur while `busy` is high are ignored.
- R10: While `rst_n` is low, `busy` and `cell_we` are low and the controller is in POR_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address: page in [16:7], slot in [6:0] |
| din | input | 8 | Write data |
| busy | output | 1 | Programming period in progress |
| cell_we | output | 1 | One-cycle array write strobe |
| cell_addr | output | 17 | Array address of the current commit |
| cell_data | output | 8 | Array data of the current commit |

## Verification
The load path is driven by several kinds of host traffic:
- out-of-order slots with one slot rewritten, which separates a last-value buffer from a first-value or append buffer;
- a single byte, and a full page of 128 bytes, which exercise both ends of the commit range and the exact length of `busy`;
- a foreign-page byte placed mid-window, which shows whether the page lock holds and whether that byte wrongly restarts the gap timer;
- chip-enable-controlled strobes, where the address and data are changed just outside the overlap, which tell the correct latch instants from an edge of one strobe alone;
- strobes with output enable low, strobes during `busy`, strobes before the power-up delay ends, and a supply drop in the middle of a load, each of which must leave no trace at the commit port.

A cycle model in the bench predicts `busy`, `cell_we`, `cell_addr` and `cell_data` on every clock.

// File: rtl/eepl_pkg.sv
package eepl_pkg;

    typedef enum logic [2:0] {
        ST_POR_WAIT = 3'd0,
        ST_IDLE     = 3'd1,
        ST_LOAD     = 3'd2,
        ST_PROG     = 3'd3,
        ST_COMMIT   = 3'd4
    } eepl_state_e;

endpackage

// File: rtl/eepl_strobe_sync.sv
// Samples the host strobes and marks the start and end of a write overlap.
module eepl_strobe_sync #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              byte_vld,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0] byte_data
);

    logic              wr_act;
    logic              wr_act_q;
    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] din_q;

    // Overlap of both strobes, and not blocked by output enable.
    assign wr_act = ~ce_n & ~we_n & oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            addr_lat <= '0;
            din_q    <= '0;
        end else begin
            wr_act_q <= wr_act;
            din_q    <= din;
            // Later falling strobe: first cycle of the overlap.
            if (wr_act && !wr_act_q) begin
                addr_lat <= addr;
            end
        end
    end

    // Earlier rising strobe: data from the last cycle of the overlap.
    assign byte_vld  = wr_act_q & ~wr_act;
    assign byte_addr = addr_lat;
    assign byte_data = din_q;

endmodule

// File: rtl/eepl_page_buf.sv
// Page buffer: one data register and one valid flag per slot.
module eepl_page_buf #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);

    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS*DATA_W-1:0] data_flat;
    logic [SLOTS-1:0]        vld_flat;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              v_q;
        logic              hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (hit) begin
                d_q <= wr_data;
                v_q <= 1'b1;
            end
        end

        assign data_flat[g*DATA_W +: DATA_W] = d_q;
        assign vld_flat[g]                   = v_q;
    end

    assign rd_data = data_flat[rd_idx*DATA_W +: DATA_W];
    assign rd_vld  = vld_flat[rd_idx];

endmodule

// File: rtl/eepl_ctrl.sv
// Load / program / commit sequencer.
module eepl_ctrl
    import eepl_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int IDX_W       = 7,
    parameter int GAP_CYCLES  = 7500,
    parameter int PROG_CYCLES = 250000,
    parameter int POR_CYCLES  = 250000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_good,
    input  logic                    byte_vld,
    input  logic [ADDR_W-IDX_W-1:0] byte_page,
    input  logic                    slot_vld,
    output logic                    buf_wr,
    output logic                    buf_clr,
    output logic [IDX_W-1:0]        slot_idx,
    output logic [ADDR_W-IDX_W-1:0] page,
    output logic                    busy,
    output logic                    cell_we
);

    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam int T_A    = (GAP_CYCLES > PROG_CYCLES) ? GAP_CYCLES : PROG_CYCLES;
    localparam int T_MAX  = (T_A > POR_CYCLES) ? T_A : POR_CYCLES;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = '1;

    eepl_state_e       state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [IDX_W-1:0]  idx_q, idx_nx;
    logic [PAGE_W-1:0] page_q, page_nx;
    logic              page_hit;

    assign page_hit = byte_vld && (byte_page == page_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POR_WAIT;
            cnt_q   <= '0;
            idx_q   <= '0;
            page_q  <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            idx_q   <= idx_nx;
            page_q  <= page_nx;
        end
    end

    // Next state.
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        idx_nx   = idx_q;
        page_nx  = page_q;
        if (!pwr_good) begin
            state_nx = ST_POR_WAIT;
            cnt_nx   = '0;
            idx_nx   = '0;
        end else begin
            unique case (state_q)
                ST_POR_WAIT: begin
                    if (cnt_q == POR_LAST) begin
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + CNT_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (byte_vld) begin
                        state_nx = ST_LOAD;
                        page_nx  = byte_page;
                        cnt_nx   = '0;
                    end
                end
                ST_LOAD: begin
                    if (page_hit) begin
                        cnt_nx = '0;
                    end else if (cnt_q == GAP_LAST) begin
                        state_nx = ST_PROG;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + CNT_W'(1);
                    end
                end
                ST_PROG: begin
                    if (cnt_q == PROG_LAST) begin
                        state_nx = ST_COMMIT;
                        cnt_nx   = '0;
                        idx_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + CNT_W'(1);
                    end
                end
                ST_COMMIT: begin
                    if (idx_q == IDX_LAST) begin
                        state_nx = ST_IDLE;
                        idx_nx   = '0;
                    end else begin
                        idx_nx = idx_q + IDX_W'(1);
                    end
                end
                default: begin
                    state_nx = ST_POR_WAIT;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        busy    = 1'b0;
        cell_we = 1'b0;
        unique case (state_q)
            ST_POR_WAIT: buf_clr = 1'b1;
            ST_IDLE:     buf_wr  = pwr_good && byte_vld;
            ST_LOAD:     buf_wr  = pwr_good && page_hit;
            ST_PROG:     busy    = 1'b1;
            ST_COMMIT: begin
                busy    = 1'b1;
                cell_we = slot_vld;
                buf_clr = (idx_q == IDX_LAST);
            end
            default:     buf_clr = 1'b1;
        endcase
        if (!pwr_good) begin
            buf_clr = 1'b1;
        end
    end

    assign slot_idx = idx_q;
    assign page     = page_q;

endmodule

// File: rtl/eepl_page_loader.sv
// Top: page write load controller.
module eepl_page_loader #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 7,
    parameter int GAP_CYCLES  = 7500,
    parameter int PROG_CYCLES = 250000,
    parameter int POR_CYCLES  = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              cell_we,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [DATA_W-1:0] cell_data
);

    localparam int PAGE_W = ADDR_W - IDX_W;

    logic              byte_vld;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] byte_data;
    logic              buf_wr;
    logic              buf_clr;
    logic [IDX_W-1:0]  slot_idx;
    logic [PAGE_W-1:0] page;
    logic              slot_vld;
    logic [DATA_W-1:0] slot_data;

    eepl_strobe_sync #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .din       (din),
        .byte_vld  (byte_vld),
        .byte_addr (byte_addr),
        .byte_data (byte_data)
    );

    eepl_page_buf #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (byte_addr[IDX_W-1:0]),
        .wr_data (byte_data),
        .rd_idx  (slot_idx),
        .rd_data (slot_data),
        .rd_vld  (slot_vld)
    );

    eepl_ctrl #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .GAP_CYCLES  (GAP_CYCLES),
        .PROG_CYCLES (PROG_CYCLES),
        .POR_CYCLES  (POR_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .byte_vld  (byte_vld),
        .byte_page (byte_addr[ADDR_W-1:IDX_W]),
        .slot_vld  (slot_vld),
        .buf_wr    (buf_wr),
        .buf_clr   (buf_clr),
        .slot_idx  (slot_idx),
        .page      (page),
        .busy      (busy),
        .cell_we   (cell_we)
    );

    assign cell_addr = {page, slot_idx};
    assign cell_data = slot_data;

endmodule

// File: rtl/eepl_page_loader_chk.sv
// Temporal checks on the commit port.
module eepl_page_loader_chk #(
    parameter int ADDR_W = 17,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic              busy,
    input logic              cell_we,
    input logic [ADDR_W-1:0] cell_addr
);

    // R8: array writes happen only inside the busy period
    a_r8_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cell_we |-> busy);

    // R7: back-to-back commits walk the slots upward by one
    a_r7_commit_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_we && $past(cell_we)) |-> (cell_addr == $past(cell_addr) + ADDR_W'(1)));

    // R4: the page on the commit port does not change during one busy period
    a_r4_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cell_addr[ADDR_W-1:IDX_W] == $past(cell_addr[ADDR_W-1:IDX_W])));

    // R6: the cycle busy rises is program time, never a commit
    a_r6_rise_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !cell_we);

    // R7: busy lasts more than one cycle while supply stays good
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && pwr_good) |=> busy);

    // R3: loss of supply ends any busy period at the next edge
    a_r3_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !busy);

endmodule

bind eepl_page_loader eepl_page_loader_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .busy      (busy),
    .cell_we   (cell_we),
    .cell_addr (cell_addr)
);

// File: tb/eepl_page_loader_tb_top.sv
`timescale 1ns/1ps
module eepl_page_loader_tb_top;

    localparam int GAP  = 20;
    localparam int PROG = 30;
    localparam int POR  = 40;
    localparam int NSLOT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b1;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        busy;
    logic        cell_we;
    logic [16:0] cell_addr;
    logic [7:0]  cell_data;

    always #10 clk = ~clk;   // 50 MHz

    eepl_page_loader #(
        .GAP_CYCLES  (GAP),
        .PROG_CYCLES (PROG),
        .POR_CYCLES  (POR)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .din       (din),
        .busy      (busy),
        .cell_we   (cell_we),
        .cell_addr (cell_addr),
        .cell_data (cell_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_phase = 0;      // 0 hold-off, 1 idle, 2 loading, 3 programming, 4 committing
    int  m_cnt = 0;
    int  m_idx = 0;
    int  m_page = 0;
    int  m_alat = 0;
    int  m_dprev = 0;
    bit  m_aprev = 0;
    bit  m_live = 0;
    int  m_buf [NSLOT];
    bit  m_val [NSLOT];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_idx = 0; m_page = 0;
            m_alat = 0; m_dprev = 0; m_aprev = 0; m_live = 0;
            foreach (m_val[i]) m_val[i] = 0;
        end else begin
            bit act;
            bit fin;
            int bpage;
            int bslot;
            act   = !ce_n && !we_n && oe_n;
            fin   = !act && m_aprev;
            bpage = m_alat / NSLOT;
            bslot = m_alat % NSLOT;
            m_live = 1;
            if (!pwr_good) begin
                m_phase = 0; m_cnt = 0; m_idx = 0;
                foreach (m_val[i]) m_val[i] = 0;
            end else begin
                case (m_phase)
                    0: if (m_cnt == POR - 1) begin m_phase = 1; m_cnt = 0; end
                       else m_cnt++;
                    1: if (fin) begin
                           m_page = bpage; m_buf[bslot] = m_dprev; m_val[bslot] = 1;
                           m_phase = 2; m_cnt = 0;
                       end
                    2: if (fin && bpage == m_page) begin
                           m_buf[bslot] = m_dprev; m_val[bslot] = 1; m_cnt = 0;
                       end else if (m_cnt == GAP - 1) begin m_phase = 3; m_cnt = 0; end
                       else m_cnt++;
                    3: if (m_cnt == PROG - 1) begin m_phase = 4; m_cnt = 0; m_idx = 0; end
                       else m_cnt++;
                    default: if (m_idx == NSLOT - 1) begin
                           m_phase = 1; m_idx = 0;
                           foreach (m_val[i]) m_val[i] = 0;
                       end else m_idx++;
                endcase
            end
            if (act && !m_aprev) m_alat = int'(addr);
            m_aprev = act;
            m_dprev = int'(din);
        end
    end

    // ---------------- per-cycle comparison and commit log ----------------
    int got [int];
    int ncommit = 0;
    int busy_len = 0;
    bit busy_seen = 0;

    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            bit e_busy;
            bit e_we;
            e_busy = (m_phase == 3 || m_phase == 4);
            e_we   = (m_phase == 4) && m_val[m_idx];
            chk(busy == e_busy, "R6 busy vs model", busy, e_busy);
            chk(cell_we == e_we, "R8 cell_we vs model", cell_we, e_we);
            if (e_we) begin
                chk(int'(cell_addr) == m_page * NSLOT + m_idx, "R7 cell_addr vs model",
                    cell_addr, m_page * NSLOT + m_idx);
                chk(int'(cell_data) == m_buf[m_idx], "R5 cell_data vs model",
                    cell_data, m_buf[m_idx]);
            end
            if (cell_we) begin
                got[int'(cell_addr)] = int'(cell_data);
                ncommit++;
            end
            if (busy) begin
                busy_len++;
                busy_seen = 1;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic int pa(input int pg, input int sl);
        return pg * NSLOT + sl;
    endfunction

    task automatic clear_log();
        got.delete();
        ncommit = 0;
        busy_len = 0;
        busy_seen = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 17'(a); din = 8'(d); ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    // we_n falls first with a wrong address; ce_n falls later with the right one.
    // ce_n rises first, then din is corrupted before we_n rises.
    task automatic wr_ce_ctrl(input int bad_a, input int a, input int d);
        @(negedge clk);
        addr = 17'(bad_a); din = 8'(d); we_n = 1'b0;
        @(negedge clk);
        addr = 17'(a); ce_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; din = 8'(~d);
        @(negedge clk);
        we_n = 1'b1; addr = 17'(bad_a);
        @(negedge clk);
    endtask

    task automatic wr_oe_low(input int a, input int d);
        @(negedge clk);
        addr = 17'(a); din = 8'(d); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_busy_high();
        for (int k = 0; k < 500 && !busy; k++) @(negedge clk);
    endtask

    task automatic wait_done();
        wait_busy_high();
        for (int k = 0; k < 500 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 busy in reset", busy, 0);
        chk(cell_we == 1'b0, "R10 cell_we in reset", cell_we, 0);
        rst_n = 1'b1;

        // R3: writes during the power-up hold-off are dropped
        clear_log();
        wr(pa(2, 4), 8'hAA);
        repeat (POR + GAP + PROG + 10) @(negedge clk);
        chk(ncommit == 0, "R3 write during hold-off", ncommit, 0);
        chk(busy_seen == 0, "R3 no busy after hold-off write", busy_seen, 0);

        // R5: any order, rewrite replaces
        clear_log();
        wr(pa(9'h155, 5), 8'h11);
        wr(pa(9'h155, 3), 8'h22);
        wr(pa(9'h155, 127), 8'h33);
        wr(pa(9'h155, 0), 8'h44);
        wr(pa(9'h155, 3), 8'h55);
        wait_done();
        chk(ncommit == 4, "R8 commits in out-of-order window", ncommit, 4);
        chk(got.exists(pa(9'h155, 3)) && got[pa(9'h155, 3)] == 8'h55,
            "R5 rewritten slot keeps last value", got.exists(pa(9'h155, 3)) ? got[pa(9'h155, 3)] : -1, 8'h55);
        chk(got.exists(pa(9'h155, 127)) && got[pa(9'h155, 127)] == 8'h33,
            "R5 top slot", got.exists(pa(9'h155, 127)) ? got[pa(9'h155, 127)] : -1, 8'h33);
        chk(!got.exists(pa(9'h155, 1)), "R8 untouched slot not written", got.exists(pa(9'h155, 1)), 0);

        // R8: single byte window
        clear_log();
        wr(pa(2, 9), 8'h5A);
        wait_done();
        chk(ncommit == 1, "R8 single byte commit", ncommit, 1);

        // R4: foreign page byte is ignored
        clear_log();
        wr(pa(16, 1), 8'h01);
        wr(pa(17, 2), 8'h02);
        wr(pa(16, 3), 8'h03);
        wait_done();
        chk(ncommit == 2, "R4 commits with foreign byte", ncommit, 2);
        chk(!got.exists(pa(17, 2)) && !got.exists(pa(16, 2)), "R4 foreign byte dropped", ncommit, 2);

        // R2: output enable low blocks the write
        clear_log();
        wr_oe_low(pa(20, 7), 8'h77);
        repeat (GAP + PROG + 20) @(negedge clk);
        chk(ncommit == 0 && busy_seen == 0, "R2 oe_n low inhibits", ncommit, 0);

        // R1: chip-enable-controlled latch instants
        clear_log();
        wr_ce_ctrl(pa(7, 8), pa(3, 4), 8'h9C);
        wait_done();
        chk(ncommit == 1, "R1 one byte from ce-controlled write", ncommit, 1);
        chk(got.exists(pa(3, 4)) && got[pa(3, 4)] == 8'h9C, "R1 address and data latch",
            got.exists(pa(3, 4)) ? got[pa(3, 4)] : -1, 8'h9C);

        // R9: strobes during busy are ignored
        clear_log();
        wr(pa(4, 1), 8'h61);
        wait_busy_high();
        wr(pa(5, 2), 8'h62);
        for (int k = 0; k < 500 && busy; k++) @(negedge clk);
        busy_seen = 0;
        repeat (GAP + 10) @(negedge clk);
        chk(ncommit == 1, "R9 only first window commits", ncommit, 1);
        chk(busy_seen == 0, "R9 no second window", busy_seen, 0);

        // R7/R8: full page
        clear_log();
        for (int s = 0; s < NSLOT; s++) wr(pa(10'h3FF, s), s ^ 8'hA5);
        wait_done();
        chk(ncommit == NSLOT, "R8 full page commits", ncommit, NSLOT);
        chk(busy_len == PROG + NSLOT, "R7 busy length", busy_len, PROG + NSLOT);
        chk(got.exists(pa(10'h3FF, 77)) && got[pa(10'h3FF, 77)] == (77 ^ 8'hA5), "R7 slot value",
            got.exists(pa(10'h3FF, 77)) ? got[pa(10'h3FF, 77)] : -1, 77 ^ 8'hA5);

        // R3: supply drop discards the load and restarts the hold-off
        clear_log();
        wr(pa(6, 0), 8'h01);
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        pwr_good = 1'b1;
        repeat (POR + GAP + PROG + 20) @(negedge clk);
        chk(ncommit == 0, "R3 supply drop discards", ncommit, 0);
        wr(pa(6, 0), 8'h02);
        wait_done();
        chk(ncommit == 1 && got.exists(pa(6, 0)) && got[pa(6, 0)] == 8'h02, "R3 write after recovery",
            ncommit, 1);

        repeat (5) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule